// File: doc/BRIEF.md
# Multishape PWM Reference Generator

This block produces the signed modulating samples that a multicarrier PWM comparator compares against its carriers. A single phase accumulator advances by a programmable increment on every enabled clock. From it the block derives three phase references spaced a third of a cycle apart, and for each of them a companion sample half a cycle away, which is the inverted reference used by unipolar modulation. Together these make six output lanes.

Three wave shapes can be selected. The first is a plain sine from a quarter-wave table. The second is a flat-topped sine whose magnitude is clipped to the sine-of-60-degree level, so it stays constant across a 60-degree window in each half cycle. The third is a stepped wave of 200 intervals per cycle, each holding a level written by software while the block is stopped. A 16-bit modulation index scales every sample. The full-scale peak depends on the carrier strategy in use: disposition or variable-frequency, phase shift, or overlapping carriers. Scaling clamps to the output range and does not wrap.

Top module: `pwmref_gen`

## Requirements
- R1: While `en` is high the 32-bit phase advances by `phase_inc` on each clock, modulo 2^32. While `en` is low the phase is cleared to 0 on each clock.
- R2: Phase lane k (k = 0, 1, 2) uses phase + floor(k*2^32/3), modulo 2^32.
- R3: Each `inv_o[k]` is the same reference as `ref_o[k]`, evaluated at the lane phase + 2^31.
- R4: With `shape_sel`=0 (sine), the unit sample is found from the lane phase p as follows.
  - q = p[31:30] and j = p[29:24].
  - m = j for even q, and m = 63-j for odd q.
  - t = round(32767*sin((m+0.5)*pi/128)).
  - The unit sample is t for q<2 and -t for q>=2.
- R5: With `shape_sel`=1 (flat top), the unit sample is the sine sample of R4 with its magnitude limited to L = round(32767*sin(60 degrees)) = 28377.
- R6: With `shape_sel`=2 or 3 (stepped), the unit sample is table entry floor(p[31:16]*200/65536), which lies in 0..199.
- R7: A write with `tbl_we` high and `en` low stores `tbl_data` into entry `tbl_addr` when `tbl_addr` < 200. A write while `en` is high is ignored.
- R8: The output is floor(u*M*G/2^29), where u is the unit sample and M is `mod_idx` as an unsigned value with 14 fraction bits (1.0 = 16384). G depends on `strat_sel`:
  - 12000 (2 carriers x 6000) for code 0 (disposition or variable frequency) and for code 3.
  - 6000 for code 1 (phase shift).
  - 7500 (5 levels x 6000 / 4) for code 2 (overlapping).
- R9: Results outside -32768..32767 saturate to the nearest limit.
- R10: An output reflects the accumulator value from three clocks earlier.
- R11: During and just after reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; phase held at zero when low |
| phase_inc | input | 32 | Phase increment per clock |
| shape_sel | input | 2 | 0 sine, 1 flat top, 2/3 stepped |
| strat_sel | input | 2 | Carrier strategy for peak scaling |
| mod_idx | input | 16 | Modulation index, 14 fraction bits |
| tbl_we | input | 1 | Step table write strobe |
| tbl_addr | input | 8 | Step table entry |
| tbl_data | input | 16 | Signed step level |
| ref_o | output | 3x16 | Signed references, one per phase |
| inv_o | output | 3x16 | Signed half-cycle-shifted references |

## Verification
Saturation and the inverted output can act in the same cycle. At 90 degrees with an index of 3.0, the main lane of phase 0 clamps to +32767 while its inverted lane clamps to -32768. One vector provokes this, and the expected value for every lane is computed from the rounding and clamping formulas.

A table write can also arrive while the block is running. The bench freezes the phase on stepped interval 0, issues a write there, and requires the output to stay at the old level. It then repeats the write with the block stopped and requires the new level to appear.

// File: rtl/pwmref_pkg.sv
package pwmref_pkg;

  typedef enum logic [1:0] {
    SHAPE_SINE  = 2'd0,
    SHAPE_FLAT  = 2'd1,
    SHAPE_STEP  = 2'd2,
    SHAPE_STEPB = 2'd3
  } shape_e;

  localparam logic [1:0] STRAT_PSHIFT  = 2'd1;
  localparam logic [1:0] STRAT_OVERLAP = 2'd2;

  localparam real PI = 3.14159265358979323846;

endpackage

// File: rtl/pwmref_phase_acc.sv
module pwmref_phase_acc #(
  parameter int PW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [PW-1:0] inc,
  output logic [PW-1:0] phase
);

  // R1: free-running modulo-2^PW accumulator, cleared while stopped
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      phase <= '0;
    end else begin
      phase <= phase + inc;
    end
  end

endmodule

// File: rtl/pwmref_sine_rom.sv
module pwmref_sine_rom
  import pwmref_pkg::*;
#(
  parameter int SW    = 16,
  parameter int QBITS = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [QBITS-1:0] addr,
  output logic [SW-1:0]    q
);

  localparam int  QDEPTH = 1 << QBITS;
  localparam real AMP    = (2.0 ** (SW - 1)) - 1.0;

  logic [SW-1:0] tab [QDEPTH];

  // R4: quarter-wave samples taken at bin centres so mirroring is exact
  for (genvar gi = 0; gi < QDEPTH; gi++) begin : g_tab
    localparam real ANG = (real'(gi) + 0.5) * PI / (2.0 * real'(QDEPTH));
    localparam int  VAL = $rtoi(AMP * $sin(ANG) + 0.5);
    assign tab[gi] = SW'(VAL);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      q <= tab[addr];
    end
  end

endmodule

// File: rtl/pwmref_lane.sv
module pwmref_lane
  import pwmref_pkg::*;
#(
  parameter int PW       = 32,
  parameter int SW       = 16,
  parameter int QBITS    = 6,
  parameter int NSTEP    = 200,
  parameter int IDXW     = 8,
  parameter int OUT_W    = 16,
  parameter int KW       = 40,
  parameter int SHIFT    = 29,
  parameter int FLAT_LVL = 28377,
  parameter logic [PW-1:0] OFFSET = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [PW-1:0]        phase,
  input  logic [1:0]           shape,
  input  logic [KW-1:0]        k_scale,
  input  logic                 wr_ok,
  input  logic [IDXW-1:0]      wr_addr,
  input  logic signed [SW-1:0] wr_data,
  output logic [OUT_W-1:0]     y
);

  localparam int HIW = 16;
  localparam int PRW = HIW + IDXW;
  localparam logic signed [SW-1:0] FLAT_S = SW'(FLAT_LVL);
  localparam logic signed [63:0]   YMAX   = (64'sd1 <<< (OUT_W - 1)) - 64'sd1;
  localparam logic signed [63:0]   YMIN   = -(64'sd1 <<< (OUT_W - 1));

  // R2, R3: lane phase is the shared accumulator plus a fixed offset
  logic [PW-1:0]    ph;
  logic [1:0]       quad;
  logic [QBITS-1:0] qidx;
  logic [QBITS-1:0] rom_addr;
  logic [HIW-1:0]   ph_hi;
  logic [PRW-1:0]   idx_prod;
  logic [IDXW-1:0]  rd_idx;

  assign ph       = phase + OFFSET;
  assign quad     = ph[PW-1 -: 2];
  assign qidx     = ph[PW-3 -: QBITS];
  assign rom_addr = quad[0] ? ~qidx : qidx;
  assign ph_hi    = ph[PW-1 -: HIW];
  // R6: interval index scales the phase fraction onto 0..NSTEP-1
  assign idx_prod = PRW'(ph_hi) * PRW'(NSTEP);
  assign rd_idx   = idx_prod[PRW-1 -: IDXW];

  // stage 1: table reads
  logic [SW-1:0]        rom_q;
  logic                 neg_q;
  logic signed [SW-1:0] step_q;
  logic signed [SW-1:0] step_mem [NSTEP];

  pwmref_sine_rom #(.SW(SW), .QBITS(QBITS)) u_rom (
    .clk  (clk),
    .rst  (rst),
    .addr (rom_addr),
    .q    (rom_q)
  );

  // R7: write port qualified upstream; one copy per lane for a private read port
  always_ff @(posedge clk) begin
    if (wr_ok) begin
      step_mem[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= '0;
      neg_q  <= 1'b0;
    end else begin
      step_q <= step_mem[rd_idx];
      neg_q  <= quad[1];
    end
  end

  // stage 2: shape selection
  logic signed [SW-1:0] rom_s;
  logic signed [SW-1:0] mag;
  logic signed [SW-1:0] unit_d;
  logic signed [SW-1:0] u_q;

  assign rom_s = $signed(rom_q);
  // R5: clip magnitude at the 60-degree level
  assign mag   = (rom_s > FLAT_S) ? FLAT_S : rom_s;

  always_comb begin
    case (shape_e'(shape))
      SHAPE_SINE: unit_d = neg_q ? -rom_s : rom_s;
      SHAPE_FLAT: unit_d = neg_q ? -mag : mag;
      default:    unit_d = step_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      u_q <= '0;
    end else begin
      u_q <= unit_d;
    end
  end

  // stage 3: scaling with saturation (R8, R9)
  logic signed [63:0] u_ext;
  logic signed [63:0] k_ext;
  logic signed [63:0] prod;
  logic signed [63:0] scaled;

  assign u_ext  = 64'(u_q);
  assign k_ext  = $signed(64'(k_scale));
  assign prod   = u_ext * k_ext;
  assign scaled = prod >>> SHIFT;

  always_ff @(posedge clk) begin
    if (rst) begin
      y <= '0;
    end else if (scaled > YMAX) begin
      y <= OUT_W'(YMAX);
    end else if (scaled < YMIN) begin
      y <= OUT_W'(YMIN);
    end else begin
      y <= OUT_W'(scaled);
    end
  end

endmodule

// File: rtl/pwmref_gen.sv
module pwmref_gen
  import pwmref_pkg::*;
#(
  parameter int PW      = 32,
  parameter int NPH     = 3,
  parameter int SW      = 16,
  parameter int QBITS   = 6,
  parameter int NSTEP   = 200,
  parameter int OUT_W   = 16,
  parameter int MI_W    = 16,
  parameter int MI_FRAC = 14,
  parameter int LEVELS  = 5,
  parameter int CARR_PP = 6000,
  localparam int IDXW   = $clog2(NSTEP)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      en,
  input  logic [PW-1:0]             phase_inc,
  input  logic [1:0]                shape_sel,
  input  logic [1:0]                strat_sel,
  input  logic [MI_W-1:0]           mod_idx,
  input  logic                      tbl_we,
  input  logic [IDXW-1:0]           tbl_addr,
  input  logic [SW-1:0]             tbl_data,
  output logic [NPH-1:0][OUT_W-1:0] ref_o,
  output logic [NPH-1:0][OUT_W-1:0] inv_o
);

  localparam int NCARR    = (LEVELS - 1) / 2;
  localparam int G_DISP   = NCARR * CARR_PP;
  localparam int G_PS     = CARR_PP;
  localparam int G_OV     = (LEVELS * CARR_PP) / 4;
  localparam int GW       = 24;
  localparam int KW       = MI_W + GW;
  localparam int SHIFT    = SW - 1 + MI_FRAC;
  localparam int FLAT_LVL = $rtoi(((2.0 ** (SW - 1)) - 1.0) * $sin(PI / 3.0) + 0.5);

  logic [PW-1:0] phase_q;

  pwmref_phase_acc #(.PW(PW)) u_acc (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .inc   (phase_inc),
    .phase (phase_q)
  );

  // R8: peak per unit index depends on the carrier strategy
  logic [GW-1:0] gain;
  always_comb begin
    case (strat_sel)
      STRAT_PSHIFT:  gain = GW'(G_PS);
      STRAT_OVERLAP: gain = GW'(G_OV);
      default:       gain = GW'(G_DISP);
    endcase
  end

  logic [KW-1:0] k_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      k_q <= '0;
    end else begin
      k_q <= KW'(mod_idx) * KW'(gain);
    end
  end

  // R7: only while stopped and only for existing entries
  logic wr_ok;
  assign wr_ok = tbl_we && !en && ({1'b0, tbl_addr} < (IDXW + 1)'(NSTEP));

  for (genvar k = 0; k < NPH; k++) begin : g_ph
    for (genvar h = 0; h < 2; h++) begin : g_half
      localparam logic [PW-1:0] OFS =
        PW'(((64'(k) << PW) / 64'(NPH)) + (64'(h) << (PW - 1)));
      logic [OUT_W-1:0] y;

      pwmref_lane #(
        .PW(PW), .SW(SW), .QBITS(QBITS), .NSTEP(NSTEP), .IDXW(IDXW),
        .OUT_W(OUT_W), .KW(KW), .SHIFT(SHIFT), .FLAT_LVL(FLAT_LVL),
        .OFFSET(OFS)
      ) u_lane (
        .clk     (clk),
        .rst     (rst),
        .phase   (phase_q),
        .shape   (shape_sel),
        .k_scale (k_q),
        .wr_ok   (wr_ok),
        .wr_addr (tbl_addr),
        .wr_data ($signed(tbl_data)),
        .y       (y)
      );

      if (h == 0) begin : g_main
        assign ref_o[k] = y;
      end else begin : g_inv
        assign inv_o[k] = y;
      end
    end
  end

endmodule

// File: rtl/pwmref_chk.sv
module pwmref_chk #(
  parameter int NPH   = 3,
  parameter int OUT_W = 16,
  parameter int PW    = 32,
  parameter int MI_W  = 16
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      en,
  input logic [1:0]                shape_sel,
  input logic [MI_W-1:0]           mod_idx,
  input logic [PW-1:0]             acc,
  input logic [NPH-1:0][OUT_W-1:0] ref_o,
  input logic [NPH-1:0][OUT_W-1:0] inv_o
);

  // R11
  reset_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (ref_o == '0 && inv_o == '0));

  // R1
  acc_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(en) |-> (acc == '0));

  // R8
  zero_mi_chk: assert property (@(posedge clk) disable iff (rst)
    (mod_idx == '0) |-> ##2 (ref_o == '0 && inv_o == '0));

  for (genvar k = 0; k < NPH; k++) begin : g_mir
    logic signed [OUT_W:0] pair_sum;
    assign pair_sum = $signed({ref_o[k][OUT_W-1], ref_o[k]}) +
                      $signed({inv_o[k][OUT_W-1], inv_o[k]});
    // R3
    mirror_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(shape_sel, 2) < 2'd2) |-> (pair_sum >= -1 && pair_sum <= 1));
  end

endmodule

bind pwmref_gen pwmref_chk #(
  .NPH(NPH), .OUT_W(OUT_W), .PW(PW), .MI_W(MI_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .en        (en),
  .shape_sel (shape_sel),
  .mod_idx   (mod_idx),
  .acc       (phase_q),
  .ref_o     (ref_o),
  .inv_o     (inv_o)
);

// File: tb/sim_pwmref_gen.sv
module sim_pwmref_gen;

  localparam real PI_B = 3.14159265358979323846;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             en = 1'b0;
  logic [31:0]      phase_inc = '0;
  logic [1:0]       shape_sel = '0;
  logic [1:0]       strat_sel = '0;
  logic [15:0]      mod_idx = '0;
  logic             tbl_we = 1'b0;
  logic [7:0]       tbl_addr = '0;
  logic [15:0]      tbl_data = '0;
  logic [2:0][15:0] ref_o;
  logic [2:0][15:0] inv_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  int lvl [200];

  always #10 clk = ~clk;

  pwmref_gen u0 (
    .clk(clk), .rst(rst), .en(en), .phase_inc(phase_inc),
    .shape_sel(shape_sel), .strat_sel(strat_sel), .mod_idx(mod_idx),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
    .ref_o(ref_o), .inv_o(inv_o)
  );

  typedef struct packed {
    logic [1:0]  shp;
    logic [1:0]  st;
    logic [15:0] mi;
    logic [31:0] inc;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd0, 16'd16384, 32'h1000_0000},
    '{2'd0, 2'd1, 16'd9830,  32'h5000_0000},
    '{2'd0, 2'd2, 16'd13107, 32'hC000_0000},
    '{2'd1, 2'd0, 16'd16384, 32'h4000_0000},
    '{2'd1, 2'd2, 16'd11469, 32'h2000_0000},
    '{2'd2, 2'd0, 16'd16384, 32'h0123_4567},
    '{2'd2, 2'd1, 16'd14746, 32'h8765_4321},
    '{2'd0, 2'd0, 16'd49152, 32'h4000_0000},
    '{2'd0, 2'd3, 16'd16384, 32'h1000_0000},
    '{2'd1, 2'd1, 16'd16384, 32'hF000_0000},
    '{2'd3, 2'd2, 16'd16384, 32'h3333_3333},
    '{2'd0, 2'd0, 16'd0,     32'h4000_0000}
  };

  function automatic int model(int shp, int st, int mi, longint acc, int k, int h);
    longint ph, p, g;
    int q, j, m, t, u, idx, lim;
    ph = (acc + ((longint'(k) << 32) / 3) + (longint'(h) << 31)) & 64'hFFFF_FFFF;
    if (shp < 2) begin
      q = int'(ph >> 30);
      j = int'((ph >> 24) & 63);
      m = (q % 2 == 1) ? 63 - j : j;
      t = $rtoi(32767.0 * $sin((real'(m) + 0.5) * PI_B / 128.0) + 0.5);
      lim = $rtoi(32767.0 * $sin(PI_B / 3.0) + 0.5);
      if (shp == 1 && t > lim) t = lim;
      u = (q >= 2) ? -t : t;
    end else begin
      idx = int'(((ph >> 16) * 200) >> 16);
      u = lvl[idx];
    end
    g = (st == 1) ? 6000 : (st == 2) ? 7500 : 12000;
    p = (longint'(u) * longint'(mi) * g) >>> 29;
    if (p > 32767) p = 32767;
    if (p < -32768) p = -32768;
    return int'(p);
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  function automatic int lane_val(int k, int h);
    if (h == 0) return int'($signed(ref_o[k]));
    return int'($signed(inv_o[k]));
  endfunction

  task automatic chk_all(input string tag, input int shp, input int st,
                         input int mi, input longint acc);
    int nmis = 0;
    int got1 = 0;
    int exp1 = 0;
    for (int k = 0; k < 3; k++) begin
      for (int h = 0; h < 2; h++) begin
        if (lane_val(k, h) != model(shp, st, mi, acc, k, h)) begin
          if (nmis == 0) begin
            got1 = lane_val(k, h);
            exp1 = model(shp, st, mi, acc, k, h);
          end
          nmis++;
        end
      end
    end
    chk(tag, got1 + nmis, exp1);
  endtask

  task automatic start_at(input logic [31:0] inc, input int edges);
    en = 1'b0;
    tick(2);
    en = 1'b1;
    phase_inc = inc;
    tick(edges);
    phase_inc = '0;
    tick(6);
  endtask

  initial begin
    string tag;
    int old_v, new_v;
    tick(4);
    rst = 1'b0;
    // R11: outputs still at reset value
    chk("R11 reset ref0", int'(ref_o[0]), 0);

    for (int i = 0; i < 200; i++) lvl[i] = i * 317 - 31000;
    for (int i = 0; i < 200; i++) begin
      tbl_we = 1'b1;
      tbl_addr = 8'(i);
      tbl_data = 16'(lvl[i]);
      tick(1);
    end
    tbl_we = 1'b0;

    // vector table: R2 R3 R4 R5 R6 R8 R9
    for (int v = 0; v < NV; v++) begin
      shape_sel = VECS[v].shp;
      strat_sel = VECS[v].st;
      mod_idx = VECS[v].mi;
      start_at(VECS[v].inc, 1);
      if (VECS[v].shp == 2'd0) tag = "R4 R2 R3 R8 R9 sine vector";
      else if (VECS[v].shp == 2'd1) tag = "R5 R2 R3 R8 flat vector";
      else tag = "R6 R2 R3 R8 step vector";
      chk_all(tag, int'(VECS[v].shp), int'(VECS[v].st), int'(VECS[v].mi),
              longint'(VECS[v].inc));
    end

    // R10: three-clock latency from accumulator to output
    shape_sel = 2'd0;
    strat_sel = 2'd0;
    mod_idx = 16'd16384;
    en = 1'b0;
    tick(6);
    old_v = model(0, 0, 16384, 0, 0, 0);
    new_v = model(0, 0, 16384, 64'h4000_0000, 0, 0);
    en = 1'b1;
    phase_inc = 32'h4000_0000;
    tick(1);
    phase_inc = '0;
    tick(2);
    chk("R10 before third clock", lane_val(0, 0), old_v);
    tick(1);
    chk("R10 at third clock", lane_val(0, 0), new_v);

    // R7: write while running is ignored, write while stopped lands
    shape_sel = 2'd2;
    en = 1'b0;
    tick(2);
    en = 1'b1;
    tick(1);
    tbl_we = 1'b1;
    tbl_addr = 8'd0;
    tbl_data = 16'd12345;
    tick(1);
    tbl_we = 1'b0;
    tick(5);
    chk("R7 write while enabled", lane_val(0, 0), model(2, 0, 16384, 0, 0, 0));
    en = 1'b0;
    tbl_we = 1'b1;
    tick(1);
    tbl_we = 1'b0;
    lvl[0] = 12345;
    en = 1'b1;
    tick(6);
    chk("R7 write while disabled", lane_val(0, 0), model(2, 0, 16384, 0, 0, 0));

    // R1: accumulator wraps modulo 2^32
    shape_sel = 2'd0;
    strat_sel = 2'd1;
    start_at(32'hC000_0000, 2);
    chk_all("R1 phase wrap", 0, 1, 16384, 64'h8000_0000);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule